// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a processor's memory stage and a 32-bit word-wide data memory. On each request it forms the effective address from a base register value and a signed 16-bit displacement. It then drives a word address, four byte-enables and store data copied across the lanes, all registered one cycle after the request. It also reports, in that same cycle, an access that breaks natural alignment. A misaligned access reaches the memory with no lane enabled.

When the memory returns a word for a load, the block picks the addressed byte or halfword using big-endian lane order. It then sign- or zero-extends the value to 32 bits, as the load type requires, and presents the result one cycle after the returned word. The size, offset and signedness of the most recent aligned load request are held until the response arrives. One load may be outstanding at a time.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base + sign-extended disp`; one cycle after an aligned request, `mem_addr` equals effective address bits 31:2.
- R2: `req_size` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word; 2'b11 behaves as a word.
- R3: Big-endian lanes: `mem_be[3]` enables bits 31:24 (address offset 0) and `mem_be[0]` enables bits 7:0 (offset 3). A byte at offset k enables only `mem_be[3-k]`. A halfword enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word enables 4'b1111.
- R4: For an aligned store, `mem_wdata` is the low byte repeated four times for a byte, the low halfword repeated twice for a halfword, and the data unchanged for a word.
- R5: A halfword with address bit 0 set, or a word with address bits 1:0 non-zero, raises `misalign` one cycle later with `mem_valid` low and `mem_be` all zero. A byte access never raises `misalign`.
- R6: `mem_valid` is high for exactly the cycle after each aligned request and low otherwise. `mem_we` equals `req_store` for that access.
- R7: A signed byte load returns the addressed lane sign-extended to 32 bits.
- R8: Unsigned byte and halfword loads (`req_unsigned`=1) return the lane zero-extended.
- R9: A halfword load returns bits 31:16 at offset 0 and bits 15:0 at offset 2. The signed form is sign-extended.
- R10: A word load returns the memory word unchanged.
- R11: `load_valid` is high exactly one cycle after `rsp_valid`. The result uses the attributes of the most recent aligned load request. A misaligned load does not change those attributes.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Load extension: 1 = zero, 0 = sign |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Aligned access to memory |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-enables, bit 3 = most significant lane |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Misaligned access flag |
| rsp_valid | input | 1 | Memory read word valid |
| rsp_word | input | 32 | Memory read word |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The hardest case to reach is a misaligned load that arrives between an aligned load request and its response. The held load attributes must survive it, and nothing at the ports shows them directly. The stimulus issues an aligned byte load and then a misaligned halfword load before sending the memory word. The bench then checks that the result still carries the first request's lane and extension. Negative displacements that borrow across the word boundary are exercised as well, to reach the carry path of the address sum.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int OFS_W  = $clog2(LANES);
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  typedef struct packed {
    acc_size_e        size;
    logic             zero_ext;
    logic [OFS_W-1:0] ofs;
  } load_ctx_t;

  function automatic logic is_word(acc_size_e s);
    return (s == SZ_WORD) || (s == SZ_WALT);
  endfunction

  function automatic logic bad_align(acc_size_e s, logic [OFS_W-1:0] ofs);
    if (s == SZ_HALF) return ofs[0];
    if (is_word(s))   return (ofs != '0);
    return 1'b0;
  endfunction

  // lane 0 is the most significant lane (big-endian)
  function automatic logic lane_hit(acc_size_e s, logic [OFS_W-1:0] ofs, int lane);
    logic [OFS_W-1:0] l;
    l = OFS_W'(lane);
    if (s == SZ_BYTE) return ofs == l;
    if (s == SZ_HALF) return ofs[OFS_W-1] == l[OFS_W-1];
    return 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] replicate(acc_size_e s, logic [WORD_W-1:0] d);
    if (s == SZ_BYTE) return {LANES{d[LANE_W-1:0]}};
    if (s == SZ_HALF) return {2{d[HALF_W-1:0]}};
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] extend_byte(logic [LANE_W-1:0] b, logic zext);
    return {{(WORD_W-LANE_W){b[LANE_W-1] & ~zext}}, b};
  endfunction

  function automatic logic [WORD_W-1:0] extend_half(logic [HALF_W-1:0] h, logic zext);
    return {{(WORD_W-HALF_W){h[HALF_W-1] & ~zext}}, h};
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [DISP_W-1:0]       disp,
  input  acc_size_e               size,
  output logic [ADDR_W-OFS_W-1:0] word_addr,
  output logic [OFS_W-1:0]        ofs,
  output logic                    misaligned
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] ea;

  assign disp_sx    = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea         = base + disp_sx;
  assign word_addr  = ea[ADDR_W-1:OFS_W];
  assign ofs        = ea[OFS_W-1:0];
  assign misaligned = bad_align(size, ofs);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
(
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              misaligned,
  input  logic [WORD_W-1:0] sdata,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[LANES-1-i] = ~misaligned & lane_hit(size, ofs, i);
  end

  assign wdata = replicate(size, sdata);
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_lane_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  load_ctx_t         ctx,
  output logic [WORD_W-1:0] data
);
  logic [LANE_W-1:0] lane_b [LANES];
  logic [HALF_W-1:0] half_v;

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    assign lane_b[i] = word[WORD_W-1-LANE_W*i -: LANE_W];
  end

  assign half_v = ctx.ofs[OFS_W-1] ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];

  always_comb begin
    if (ctx.size == SZ_BYTE)      data = extend_byte(lane_b[ctx.ofs], ctx.zero_ext);
    else if (ctx.size == SZ_HALF) data = extend_half(half_v, ctx.zero_ext);
    else                          data = word;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_store,
  input  logic [1:0]              req_size,
  input  logic                    req_unsigned,
  input  logic [ADDR_W-1:0]       base,
  input  logic [DISP_W-1:0]       disp,
  input  logic [31:0]             store_data,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [ADDR_W-3:0]       mem_addr,
  output logic [3:0]              mem_be,
  output logic [31:0]             mem_wdata,
  output logic                    misalign,
  input  logic                    rsp_valid,
  input  logic [31:0]             rsp_word,
  output logic                    load_valid,
  output logic [31:0]             load_data
);
  localparam int WA_W = ADDR_W - OFS_W;

  acc_size_e         size_w;
  logic [WA_W-1:0]   word_addr_w;
  logic [OFS_W-1:0]  ofs_w;
  logic              mis_w;
  logic [LANES-1:0]  be_w;
  logic [WORD_W-1:0] wdata_w;
  logic [WORD_W-1:0] load_w;
  logic              accept_w;
  logic              ld_capture_w;
  load_ctx_t         ctx_q;

  assign size_w       = acc_size_e'(req_size);
  assign accept_w     = req_valid & ~mis_w;
  assign ld_capture_w = accept_w & ~req_store;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base(base), .disp(disp), .size(size_w),
    .word_addr(word_addr_w), .ofs(ofs_w), .misaligned(mis_w)
  );

  lsu_store_lane u_store (
    .size(size_w), .ofs(ofs_w), .misaligned(mis_w),
    .sdata(store_data), .be(be_w), .wdata(wdata_w)
  );

  lsu_load_lane u_load (
    .word(rsp_word), .ctx(ctx_q), .data(load_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      misalign   <= 1'b0;
      ctx_q      <= '0;
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      mem_valid  <= accept_w;
      mem_we     <= accept_w & req_store;
      mem_be     <= req_valid ? be_w : '0;
      misalign   <= req_valid & mis_w;
      if (req_valid) mem_addr <= word_addr_w;
      if (req_valid && req_store) mem_wdata <= wdata_w;
      if (ld_capture_w) ctx_q <= '{size: size_w, zero_ext: req_unsigned, ofs: ofs_w};
      load_valid <= rsp_valid;
      if (rsp_valid) load_data <= load_w;
    end
  end
endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] base,
  input logic [DISP_W-1:0] disp,
  input logic              mem_valid,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              misalign,
  input logic              rsp_valid,
  input logic              load_valid,
  input logic [31:0]       load_data,
  input load_ctx_t         ctx_q
);
  logic [ADDR_W-1:0] ea_chk;
  assign ea_chk = base + ADDR_W'($signed(disp));

  function automatic int lane_count(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  assert_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr == $past(ea_chk[ADDR_W-1:2]));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $countones(mem_be) == lane_count($past(req_size)));

  assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_valid));

  assert_byte_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |=> !misalign);

  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(req_valid));

  assert_sign_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && $past(ctx_q.size == SZ_BYTE && !ctx_q.zero_ext))
      |-> load_data[31:8] == {24{load_data[7]}});

  assert_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && $past(ctx_q.size == SZ_BYTE && ctx_q.zero_ext))
      |-> load_data[31:8] == 24'h0);

  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid == $past(rsp_valid));
endmodule

bind lsu_lane_unit lsu_lane_checker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_lane_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .base(base), .disp(disp), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .mem_be(mem_be), .misalign(misalign), .rsp_valid(rsp_valid),
  .load_valid(load_valid), .load_data(load_data), .ctx_q(ctx_q)
);

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = '0, store_data = '0;
  logic [15:0] disp = '0;
  logic        mem_valid, mem_we, misalign, load_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, load_data;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_word = '0;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model: attributes of the last aligned load
  int          m_size = 0;
  bit          m_uns  = 0;
  int          m_ofs  = 0;

  always #2.5 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .disp(disp),
    .store_data(store_data), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .load_valid(load_valid), .load_data(load_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input string tag, input bit st, input int sz, input bit uns,
                       input logic [31:0] b, input logic [15:0] d, input logic [31:0] sd);
    logic [31:0] ea, wd;
    logic [3:0]  be;
    int          o;
    bit          bad;
    ea  = b + 32'(int'($signed(d)));
    o   = int'(ea[1:0]);
    bad = (sz == 1 && o % 2 != 0) || (sz >= 2 && o != 0);
    if (bad)          be = 4'b0000;
    else if (sz == 0) be = 4'b1000 >> o;
    else if (sz == 1) be = 4'b1100 >> o;
    else              be = 4'b1111;
    if (sz == 0)      wd = {24'h0, sd[7:0]} * 32'h01010101;
    else if (sz == 1) wd = {16'h0, sd[15:0]} * 32'h00010001;
    else              wd = sd;
    req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_unsigned = uns;
    base = b; disp = d; store_data = sd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 mem_valid"}, 32'(mem_valid), 32'(!bad));
    chk({tag, " R5 misalign"}, 32'(misalign), 32'(bad));
    chk({tag, " R3 mem_be"}, 32'(mem_be), 32'(be));
    if (!bad) begin
      chk({tag, " R1 mem_addr"}, 32'(mem_addr), ea >> 2);
      chk({tag, " R6 mem_we"}, 32'(mem_we), 32'(st));
      if (st) chk({tag, " R4 mem_wdata"}, mem_wdata, wd);
      else begin m_size = sz; m_uns = uns; m_ofs = o; end
    end
  endtask

  task automatic respond(input string tag, input logic [31:0] w);
    logic [31:0] v;
    if (m_size == 0) begin
      v = (w >> (8 * (3 - m_ofs))) & 32'hFF;
      if (!m_uns && v[7]) v = v | 32'hFFFFFF00;
    end else if (m_size == 1) begin
      v = (w >> (16 * (1 - m_ofs / 2))) & 32'hFFFF;
      if (!m_uns && v[15]) v = v | 32'hFFFF0000;
    end else v = w;
    rsp_valid = 1'b1; rsp_word = w;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk({tag, " R11 load_valid"}, 32'(load_valid), 32'd1);
    chk({tag, " load_data"}, load_data, v);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk({tag, " R6 idle mem_valid"}, 32'(mem_valid), 32'd0);
    chk({tag, " R11 idle load_valid"}, 32'(load_valid), 32'd0);
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset mem_valid", 32'(mem_valid), 32'd0);
    chk("R12 reset mem_be", 32'(mem_be), 32'd0);
    chk("R12 reset misalign", 32'(misalign), 32'd0);
    chk("R12 reset load_data", load_data, 32'd0);
    chk("R12 reset load_valid", 32'(load_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 4; k++)
      issue("R3 R4 store byte", 1, 0, 0, 32'h0000_2000 + 32'(k), 16'h0010, 32'hCAFE_BE5A);
    issue("R4 store half ofs0", 1, 1, 0, 32'h0000_3000, 16'h0000, 32'h1234_ABCD);
    issue("R4 store half ofs2", 1, 1, 0, 32'h0000_3000, 16'h0002, 32'h1234_ABCD);
    issue("R5 store half ofs1", 1, 1, 0, 32'h0000_3000, 16'h0001, 32'h1234_ABCD);
    issue("R5 store half ofs3", 1, 1, 0, 32'h0000_3001, 16'h0002, 32'h1234_ABCD);
    issue("R4 store word", 1, 2, 0, 32'h0000_4000, 16'h0004, 32'hDEAD_BEEF);
    issue("R5 store word ofs2", 1, 2, 0, 32'h0000_4000, 16'h0006, 32'hDEAD_BEEF);
    issue("R5 store word ofs1", 1, 2, 0, 32'h0000_4001, 16'h0000, 32'hDEAD_BEEF);
    issue("R2 size3 word", 1, 3, 0, 32'h0000_5000, 16'h0008, 32'h0BAD_F00D);
    issue("R2 size3 misaligned", 1, 3, 0, 32'h0000_5000, 16'h0003, 32'h0BAD_F00D);
    issue("R1 negative disp", 1, 2, 0, 32'h0000_1000, 16'hFFFC, 32'h5555_AAAA);
    issue("R1 negative borrow", 1, 0, 0, 32'h0001_0000, 16'h8001, 32'h0000_0077);
    issue("R1 wrap high", 1, 0, 0, 32'hFFFF_FFF0, 16'h0013, 32'h0000_0042);
    idle("R6 gap");

    for (int k = 0; k < 4; k++) begin
      issue("R7 load byte signed", 0, 0, 0, 32'h0000_6000, 16'(k), 32'h0);
      respond("R7 byte signed", 32'h80F1_7F01);
    end
    for (int k = 0; k < 4; k++) begin
      issue("R8 load byte unsigned", 0, 0, 1, 32'h0000_6000, 16'(k), 32'h0);
      respond("R8 byte unsigned", 32'h80F1_7F01);
    end
    issue("R9 load half signed ofs0", 0, 1, 0, 32'h0000_7000, 16'h0000, 32'h0);
    respond("R9 half signed ofs0", 32'h80F1_7F01);
    issue("R9 load half signed ofs2", 0, 1, 0, 32'h0000_7000, 16'h0002, 32'h0);
    respond("R9 half signed ofs2 positive", 32'h80F1_7F01);
    issue("R9 load half signed ofs2 neg", 0, 1, 0, 32'h0000_7000, 16'h0002, 32'h0);
    respond("R9 half signed ofs2 negative", 32'h1234_9ABC);
    issue("R8 load half unsigned", 0, 1, 1, 32'h0000_7000, 16'h0000, 32'h0);
    respond("R8 half unsigned", 32'hF00D_1234);
    issue("R10 load word", 0, 2, 0, 32'h0000_8000, 16'h0000, 32'h0);
    respond("R10 word", 32'h89AB_CDEF);

    issue("R11 keep ctx byte", 0, 0, 0, 32'h0000_9000, 16'h0002, 32'h0);
    issue("R11 misaligned load", 0, 1, 1, 32'h0000_9000, 16'h0001, 32'h0);
    respond("R11 ctx survives misaligned", 32'h0011_8233);
    idle("R11 after response");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule